// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programming Sequencer

This block holds the two thresholds that a FIFO's partial-status flag logic compares against: the almost-empty offset and the almost-full offset. Each offset is kept as a pair of 9-bit registers, a low part and a high part. Software reaches them without an address. The FIFO data input and data output are shared for this access, and a rotating slot index picks the register that each access touches. The registers are visited in a fixed cycle: empty-low, empty-high, full-low, full-high, and then empty-low again.

An active-low load strobe switches the FIFO ports between normal traffic and register access. While access is enabled and the strobe is low, the block holds the FIFO array's write and read enables off. A write-clock edge with the write enable low stores the data input into the current slot. A read-clock edge with the read enable low copies the current slot onto the read-back output. Each side keeps its own index in its own clock domain, and an index survives the strobe going high, so a later access picks up at the next slot.

Whether access is enabled at all is decided by the level of the load strobe while reset is held. When the strobe is high during reset, the block ignores the strobe afterwards and passes the enables straight through. The assembled offsets are driven continuously to the flag comparators.

Top module: `offs_prog_seq`

## Requirements
- R1: Slots are visited in the order empty-low (0), empty-high (1), full-low (2), full-high (3). The access after full-high wraps to empty-low. This holds for writes and for read-backs.
- R2: When access is enabled, a rising write-clock edge with both `loadN` and `wrEnN` low loads `dataIn` into the current write slot and advances the write index.
- R3: With `loadN` low and `wrEnN` high, a write-clock edge changes no register.
- R4: With `loadN` high, the FIFO enables follow the port enables (`fifoWrEn` = !`wrEnN`, `fifoRdEn` = !`rdEnN`), `cfgMode` is 0, and no offset register changes.
- R5: When access is enabled, a rising read-clock edge with both `loadN` and `rdEnN` low places the current read slot on `rdData` and advances the read index. `rdData` holds at all other times.
- R6: Raising `loadN` keeps both indices, so the next access after `loadN` falls again continues at the following slot.
- R7: Reset sets both low-part slots to 007h and both high-part slots to 000h, returns both indices to empty-low, and clears `rdData` to 0.
- R8: `emptyOffset` = {empty-high[6:0], empty-low[8:0]} and `fullOffset` = {full-high[6:0], full-low[8:0]}. Both are 16-bit values.
- R9: The level of `loadN` at the last clock edge with `rstN` low selects the mode. If that level was high, access stays disabled: `loadN` has no effect, `cfgMode` stays 0, the enables pass through, and no register or `rdData` changes.
- R10: While `cfgMode` is 1 (access enabled and `loadN` low), `fifoWrEn` and `fifoRdEn` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous reset, active low, sampled by both clocks |
| loadN | input | 1 | Register-access strobe, active low; also the mode selector during reset |
| wrEnN | input | 1 | Write enable, active low |
| rdEnN | input | 1 | Read enable, active low |
| dataIn | input | 9 | Shared data input |
| fifoWrEn | output | 1 | Write enable to the FIFO array, active high |
| fifoRdEn | output | 1 | Read enable to the FIFO array, active high |
| cfgMode | output | 1 | High while register access takes over the ports |
| rdData | output | 9 | Register read-back value |
| emptyOffset | output | 16 | Assembled almost-empty threshold |
| fullOffset | output | 16 | Assembled almost-full threshold |

## Verification
The bench builds the block with its default parameters: 9-bit slots, 7 high bits used per offset, and reset values 007h and 000h. With one clock driving both sides, every write and read-back lands on a known edge. A short walk is enough to wrap both indices past full-high and to interrupt the sequence with the strobe raised. A high-part value with bit 8 set shows that only seven of its bits reach the assembled offset. A second reset with the strobe held high reaches the pass-through mode.

// File: rtl/offs_pkg.sv
package offs_pkg;

  localparam int SLOT_COUNT = 4;
  localparam int SLOT_IDX_W = $clog2(SLOT_COUNT);

  typedef enum logic [SLOT_IDX_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  typedef struct packed {
    logic                  wrLoad;
    logic [SLOT_IDX_W-1:0] wrIdx;
    logic                  rdLoad;
    logic [SLOT_IDX_W-1:0] rdIdx;
  } seqStrobe_t;

  function automatic logic [SLOT_IDX_W-1:0] nextSlot(input logic [SLOT_IDX_W-1:0] cur);
    return (cur == SLOT_IDX_W'(SLOT_COUNT - 1)) ? '0 : cur + 1'b1;
  endfunction

endpackage

// File: rtl/offs_ctrl.sv
module offs_ctrl
  import offs_pkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       loadN,
  input  logic       wrEnN,
  input  logic       rdEnN,
  output seqStrobe_t strobe,
  output logic       fifoWrEn,
  output logic       fifoRdEn,
  output logic       cfgMode
);

  logic                  wrProgEn;
  logic                  rdProgEn;
  logic [SLOT_IDX_W-1:0] wrIdx;
  logic [SLOT_IDX_W-1:0] rdIdx;
  logic                  wrAccess;
  logic                  rdAccess;
  logic                  wrSideMode;
  logic                  rdSideMode;

  // Each domain captures the access mode while reset is held.
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      wrProgEn <= !loadN;
      wrIdx    <= SLOT_EMPTY_LO;
    end else if (wrAccess) begin
      wrIdx <= nextSlot(wrIdx);
    end
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      rdProgEn <= !loadN;
      rdIdx    <= SLOT_EMPTY_LO;
    end else if (rdAccess) begin
      rdIdx <= nextSlot(rdIdx);
    end
  end

  always_comb begin
    wrSideMode = wrProgEn && !loadN;
    rdSideMode = rdProgEn && !loadN;
    wrAccess   = rstN && wrSideMode && !wrEnN;
    rdAccess   = rstN && rdSideMode && !rdEnN;
    fifoWrEn   = rstN && !wrEnN && !wrSideMode;
    fifoRdEn   = rstN && !rdEnN && !rdSideMode;
    cfgMode    = wrSideMode;
  end

  always_comb begin
    strobe.wrLoad = wrAccess;
    strobe.wrIdx  = wrIdx;
    strobe.rdLoad = rdAccess;
    strobe.rdIdx  = rdIdx;
  end

endmodule

// File: rtl/offs_regfile.sv
module offs_regfile
  import offs_pkg::*;
#(
  parameter int                   WORD_W     = 9,
  parameter int                   HIGH_BITS  = 7,
  parameter logic [WORD_W-1:0]    LOW_RESET  = 9'h007,
  parameter logic [WORD_W-1:0]    HIGH_RESET = 9'h000,
  localparam int                  OFFSET_W   = WORD_W + HIGH_BITS
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [WORD_W-1:0]   dataIn,
  output logic [WORD_W-1:0]   rdData,
  output logic [OFFSET_W-1:0] emptyOffset,
  output logic [OFFSET_W-1:0] fullOffset
);

  logic [WORD_W-1:0] slotQ [SLOT_COUNT];

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    localparam logic [WORD_W-1:0] RST_VAL = (s % 2 == 0) ? LOW_RESET : HIGH_RESET;
    logic hit;
    assign hit = strobe.wrLoad && (strobe.wrIdx == SLOT_IDX_W'(s));
    always_ff @(posedge wrClk) begin
      if (!rstN) begin
        slotQ[s] <= RST_VAL;
      end else if (hit) begin
        slotQ[s] <= dataIn;
      end
    end
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      rdData <= slotQ[strobe.rdIdx];
    end
  end

  always_comb begin
    emptyOffset = {slotQ[SLOT_EMPTY_HI][HIGH_BITS-1:0], slotQ[SLOT_EMPTY_LO]};
    fullOffset  = {slotQ[SLOT_FULL_HI][HIGH_BITS-1:0],  slotQ[SLOT_FULL_LO]};
  end

endmodule

// File: rtl/offs_prog_seq.sv
module offs_prog_seq
  import offs_pkg::*;
#(
  parameter int                WORD_W     = 9,
  parameter int                HIGH_BITS  = 7,
  parameter logic [WORD_W-1:0] LOW_RESET  = 9'h007,
  parameter logic [WORD_W-1:0] HIGH_RESET = 9'h000,
  localparam int               OFFSET_W   = WORD_W + HIGH_BITS
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  logic                loadN,
  input  logic                wrEnN,
  input  logic                rdEnN,
  input  logic [WORD_W-1:0]   dataIn,
  output logic                fifoWrEn,
  output logic                fifoRdEn,
  output logic                cfgMode,
  output logic [WORD_W-1:0]   rdData,
  output logic [OFFSET_W-1:0] emptyOffset,
  output logic [OFFSET_W-1:0] fullOffset
);

  seqStrobe_t strobe;

  offs_ctrl i_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .loadN    (loadN),
    .wrEnN    (wrEnN),
    .rdEnN    (rdEnN),
    .strobe   (strobe),
    .fifoWrEn (fifoWrEn),
    .fifoRdEn (fifoRdEn),
    .cfgMode  (cfgMode)
  );

  offs_regfile #(
    .WORD_W     (WORD_W),
    .HIGH_BITS  (HIGH_BITS),
    .LOW_RESET  (LOW_RESET),
    .HIGH_RESET (HIGH_RESET)
  ) i_regfile (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dataIn      (dataIn),
    .rdData      (rdData),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );

endmodule

// File: rtl/offs_prog_seq_chk.sv
module offs_prog_seq_chk #(
  parameter int WORD_W   = 9,
  parameter int OFFSET_W = 16
) (
  input logic                wrClk,
  input logic                rdClk,
  input logic                rstN,
  input logic                loadN,
  input logic                wrEnN,
  input logic                rdEnN,
  input logic                fifoWrEn,
  input logic                fifoRdEn,
  input logic                cfgMode,
  input logic [WORD_W-1:0]   rdData,
  input logic [OFFSET_W-1:0] emptyOffset,
  input logic [OFFSET_W-1:0] fullOffset
);

  AST_IDLE_WRITE_HOLDS: assert property (@(posedge wrClk) disable iff (!rstN)
    (cfgMode && wrEnN) |=> ($stable(emptyOffset) && $stable(fullOffset))); // R3

  AST_NORMAL_KEEPS_OFFSETS: assert property (@(posedge wrClk) disable iff (!rstN)
    (!cfgMode) |=> ($stable(emptyOffset) && $stable(fullOffset))); // R4

  AST_MODE_BLOCKS_FIFO: assert property (@(posedge wrClk) disable iff (!rstN)
    cfgMode |-> (!fifoWrEn && !fifoRdEn)); // R10

  AST_MODE_NEEDS_LOAD: assert property (@(posedge wrClk) disable iff (!rstN)
    loadN |-> !cfgMode); // R4

  AST_READBACK_HOLDS: assert property (@(posedge rdClk) disable iff (!rstN)
    (loadN || rdEnN) |=> $stable(rdData)); // R5

  AST_WRITE_PASSES: assert property (@(posedge wrClk) disable iff (!rstN)
    (loadN && !wrEnN) |-> fifoWrEn); // R4

endmodule

bind offs_prog_seq offs_prog_seq_chk #(
  .WORD_W   (WORD_W),
  .OFFSET_W (OFFSET_W)
) i_offs_prog_seq_chk (
  .wrClk       (wrClk),
  .rdClk       (rdClk),
  .rstN        (rstN),
  .loadN       (loadN),
  .wrEnN       (wrEnN),
  .rdEnN       (rdEnN),
  .fifoWrEn    (fifoWrEn),
  .fifoRdEn    (fifoRdEn),
  .cfgMode     (cfgMode),
  .rdData      (rdData),
  .emptyOffset (emptyOffset),
  .fullOffset  (fullOffset)
);

// File: tb/test_offs_prog_seq.sv
`timescale 1ns/1ps
module test_offs_prog_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadN = 1'b0;
  logic        wrEnN = 1'b1;
  logic        rdEnN = 1'b1;
  logic [8:0]  dataIn = '0;
  logic        fifoWrEn, fifoRdEn, cfgMode;
  logic [8:0]  rdData;
  logic [15:0] emptyOffset, fullOffset;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  offs_prog_seq i_offs_prog_seq (
    .wrClk       (clk),
    .rdClk       (clk),
    .rstN        (rstN),
    .loadN       (loadN),
    .wrEnN       (wrEnN),
    .rdEnN       (rdEnN),
    .dataIn      (dataIn),
    .fifoWrEn    (fifoWrEn),
    .fifoRdEn    (fifoRdEn),
    .cfgMode     (cfgMode),
    .rdData      (rdData),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );

  typedef struct packed {
    logic        ld;
    logic        we;
    logic        re;
    logic [8:0]  din;
    logic [15:0] eOff;
    logic [15:0] fOff;
    logic [8:0]  rd;
    logic        fw;
    logic        fr;
    logic        md;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b1,9'h011,16'h0011,16'h0007,9'h000,1'b0,1'b0,1'b1}, // R2 empty-low
    '{1'b0,1'b1,1'b1,9'h1FF,16'h0011,16'h0007,9'h000,1'b0,1'b0,1'b1}, // R3 idle
    '{1'b0,1'b0,1'b1,9'h105,16'h0A11,16'h0007,9'h000,1'b0,1'b0,1'b1}, // R8 empty-high
    '{1'b1,1'b0,1'b0,9'h0AA,16'h0A11,16'h0007,9'h000,1'b1,1'b1,1'b0}, // R4 normal
    '{1'b0,1'b0,1'b1,9'h0FF,16'h0A11,16'h00FF,9'h000,1'b0,1'b0,1'b1}, // R6 full-low
    '{1'b0,1'b0,1'b1,9'h003,16'h0A11,16'h06FF,9'h000,1'b0,1'b0,1'b1}, // R8 full-high
    '{1'b0,1'b0,1'b1,9'h1AA,16'h0BAA,16'h06FF,9'h000,1'b0,1'b0,1'b1}, // R1 wrap write
    '{1'b0,1'b1,1'b0,9'h000,16'h0BAA,16'h06FF,9'h1AA,1'b0,1'b0,1'b1}, // R5 read 0
    '{1'b0,1'b1,1'b0,9'h000,16'h0BAA,16'h06FF,9'h105,1'b0,1'b0,1'b1}, // R5 read 1
    '{1'b1,1'b1,1'b1,9'h000,16'h0BAA,16'h06FF,9'h105,1'b0,1'b0,1'b0}, // R6 pause
    '{1'b0,1'b1,1'b0,9'h000,16'h0BAA,16'h06FF,9'h0FF,1'b0,1'b0,1'b1}, // R6 resume read
    '{1'b0,1'b1,1'b0,9'h000,16'h0BAA,16'h06FF,9'h003,1'b0,1'b0,1'b1}, // R1 read 3
    '{1'b0,1'b1,1'b0,9'h000,16'h0BAA,16'h06FF,9'h1AA,1'b0,1'b0,1'b1}, // R1 wrap read
    '{1'b0,1'b1,1'b1,9'h000,16'h0BAA,16'h06FF,9'h1AA,1'b0,1'b0,1'b1}  // R5 hold
  };

  function automatic string vecTag(input int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R8";   3: return "R4";
      4: return "R6";   5: return "R8";   6: return "R1";   7: return "R5";
      8: return "R5";   9: return "R6";  10: return "R6";  11: return "R1";
      12: return "R1";  default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic ldDuringReset);
    @(negedge clk);
    rstN = 1'b0; loadN = ldDuringReset; wrEnN = 1'b1; rdEnN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1; loadN = 1'b1;
  endtask

  task automatic step(input logic ld, input logic we, input logic re, input logic [8:0] din);
    @(negedge clk);
    loadN = ld; wrEnN = we; rdEnN = re; dataIn = din;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R7 reset defaults, access enabled
    doReset(1'b0);
    #1;
    check("R7", "emptyOffset", 32'(emptyOffset), 32'h0007);
    check("R7", "fullOffset",  32'(fullOffset),  32'h0007);
    check("R7", "rdData",      32'(rdData),      32'h000);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ld, VECS[i].we, VECS[i].re, VECS[i].din);
      #1;
      check(vecTag(i), "fifoWrEn", 32'(fifoWrEn), 32'(VECS[i].fw));
      check(vecTag(i), "fifoRdEn", 32'(fifoRdEn), 32'(VECS[i].fr));
      check(vecTag(i), "cfgMode",  32'(cfgMode),  32'(VECS[i].md));
      @(posedge clk); #1;
      check(vecTag(i), "emptyOffset", 32'(emptyOffset), 32'(VECS[i].eOff));
      check(vecTag(i), "fullOffset",  32'(fullOffset),  32'(VECS[i].fOff));
      check(vecTag(i), "rdData",      32'(rdData),      32'(VECS[i].rd));
    end

    // R9 strobe high during reset: access disabled; R7 defaults restored
    doReset(1'b1);
    #1;
    check("R7", "emptyOffset after rewrite", 32'(emptyOffset), 32'h0007);
    check("R7", "fullOffset after rewrite",  32'(fullOffset),  32'h0007);
    check("R7", "rdData after reset",        32'(rdData),      32'h000);
    step(1'b0, 1'b0, 1'b0, 9'h055);
    #1;
    check("R9", "cfgMode",  32'(cfgMode),  32'h0);
    check("R9", "fifoWrEn", 32'(fifoWrEn), 32'h1);
    check("R9", "fifoRdEn", 32'(fifoRdEn), 32'h1);
    @(posedge clk); #1;
    check("R9", "emptyOffset", 32'(emptyOffset), 32'h0007);
    check("R9", "fullOffset",  32'(fullOffset),  32'h0007);
    check("R9", "rdData",      32'(rdData),      32'h000);

    // R7 index returns to empty-low after reset
    doReset(1'b0);
    step(1'b0, 1'b0, 1'b1, 9'h044);
    @(posedge clk); #1;
    check("R7", "index restart emptyOffset", 32'(emptyOffset), 32'h0044);
    check("R7", "index restart fullOffset",  32'(fullOffset),  32'h0007);
    step(1'b0, 1'b1, 1'b0, 9'h000);
    @(posedge clk); #1;
    check("R7", "read index restart", 32'(rdData), 32'h044);

    step(1'b1, 1'b1, 1'b1, 9'h000);
    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule